// File: doc/BRIEF.md
# eFuse Read Controller

This block reads a run of bytes out of a one-time-programmable fuse array on behalf of software. Software first sets two timing intervals in a configuration register: an address setup (adjust) count and a strobe count. It then writes a control register with a start address, a byte count, an array half select and a start bit. For each byte, the controller presents the array address, waits out the adjust interval, and raises the strobe for the strobe interval. It captures the byte on the last strobe cycle.

Up to 32 bytes are packed little-endian into eight readable data words, and a done flag is then raised in a status register. The array is seen as a plain byte-wide read port. Its 10-bit address is the half select on top of a 9-bit byte offset. Software polls the done flag and then reads the data words over a simple 32-bit register bus with single-cycle writes and combinational reads.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset, every register reads zero and `fuse_strobe` is low.
- R2: Byte offsets on the bus are decoded as follows: 0xd0 is control, 0xd4 is configuration, 0xd8 is status, and data word n (n = 0..7) is at 0xdc + 4n. Any other offset reads zero, and a write to it has no effect.
- R3: The control register fields are: bit 0 start/busy, bits 20:16 byte count minus one, bits 29:21 start offset, bit 30 half select. Byte i of a read is fetched from `fuse_addr` = {half, (start + i) mod 512}.
- R4: The configuration register holds the strobe count in bits 19:16 and the adjust count in bits 23:20. All other bits read zero. The values in place when a read starts govern that whole read.
- R5: For each byte, the address is held with the strobe low for adjust+1 cycles. The strobe is then high for strobe+1 cycles with the address unchanged. A read of N bytes raises the done flag N*(adjust+strobe+2) clock edges after the edge that accepts the start write.
- R6: Byte i of the read lands in data word i/4, in bits 8*(i mod 4)+7 : 8*(i mod 4).
- R7: Byte lanes at or past the requested count read zero. This includes the upper lanes of word 0 for reads of one to three bytes.
- R8: Status bit 0 is the done flag. It is set when the last byte is captured and cleared by a control write that starts a read.
- R9: A control write made while a read is in progress is ignored. Neither the running read nor the control fields change.
- R10: Control bit 0 reads one while a read is in progress and clears itself when the read completes.
- R11: Data words keep their contents after completion until the next read starts. Configuration writes and control writes with bit 0 clear do not disturb them or the done flag.
- R12: The half select bit drives the top address bit exactly as written, whatever the start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| fuse_addr | output | 10 | Array byte address: half select on top of the 9-bit offset |
| fuse_strobe | output | 1 | Array read strobe |
| fuse_rdata | input | 8 | Array read data |

## Verification
A counter that is loaded wrongly, or a stale interval, changes the done latency by whole cycles. It also changes the number of strobe-high cycles seen on the first poll after completion, so both are compared exactly against N*(adjust+strobe+2) and N*(strobe+1). A wrong byte index or address step shows up as a misplaced or wrong byte in the data words. A missed clear at start leaves stale bytes in lanes past the count. A busy-state decode fault shows up when a mid-read control write alters the fetched bytes or the control readback. Random reads mix counts, offsets that wrap at 512, both halves and all timing values.

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl #(
  parameter int          AW   = 9,
  parameter int          LW   = 5,
  parameter int          CW   = 4,
  parameter logic [7:0]  BASE = 8'hd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [AW:0]   fuse_addr,
  output logic          fuse_strobe,
  input  logic [7:0]    fuse_rdata
);
  localparam int NB       = 1 << LW;
  localparam int NW       = NB / 4;
  localparam int LEN_LSB  = 16;
  localparam int SA_LSB   = LEN_LSB + LW;
  localparam int HALF_BIT = SA_LSB + AW;
  localparam int STB_LSB  = 16;
  localparam int ADJ_LSB  = STB_LSB + CW;
  localparam logic [7:0] OFF_CFG  = BASE + 8'd4;
  localparam logic [7:0] OFF_STAT = BASE + 8'd8;
  localparam logic [7:0] OFF_DATA = BASE + 8'd12;

  typedef enum logic [1:0] {IDLE, ADJ, STB} ph_t;

  ph_t            ph;
  logic           en, half, done;
  logic [LW-1:0]  len, bidx;
  logic [AW-1:0]  sa, cur;
  logic [CW-1:0]  cfg_adj, cfg_stb, adj_l, stb_l, cnt;
  logic [7:0]     dbuf [NB];

  wire busy    = ph != IDLE;
  wire wr      = bus_sel & bus_wr;
  wire wr_ctrl = wr && bus_addr == BASE;
  wire wr_cfg  = wr && bus_addr == OFF_CFG;
  wire go      = wr_ctrl && !busy && bus_wdata[0];

  assign fuse_addr   = {half, cur};
  assign fuse_strobe = ph == STB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; en <= 1'b0; half <= 1'b0; done <= 1'b0;
      len <= '0; bidx <= '0; sa <= '0; cur <= '0;
      cfg_adj <= '0; cfg_stb <= '0; adj_l <= '0; stb_l <= '0; cnt <= '0;
      for (int i = 0; i < NB; i++) dbuf[i] <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_stb <= bus_wdata[STB_LSB +: CW];
        cfg_adj <= bus_wdata[ADJ_LSB +: CW];
      end
      if (wr_ctrl && !busy) begin
        len  <= bus_wdata[LEN_LSB +: LW];
        sa   <= bus_wdata[SA_LSB +: AW];
        half <= bus_wdata[HALF_BIT];
      end
      if (go) begin
        en    <= 1'b1;
        done  <= 1'b0;
        ph    <= ADJ;
        adj_l <= cfg_adj;
        stb_l <= cfg_stb;
        cnt   <= cfg_adj;
        bidx  <= '0;
        cur   <= bus_wdata[SA_LSB +: AW];
        for (int i = 0; i < NB; i++) dbuf[i] <= '0;
      end
      case (ph)
        ADJ: begin
          if (cnt == '0) begin
            ph  <= STB;
            cnt <= stb_l;
          end else cnt <= cnt - 1'b1;
        end
        STB: begin
          if (cnt == '0) begin
            dbuf[bidx] <= fuse_rdata;
            if (bidx == len) begin
              ph   <= IDLE;
              en   <= 1'b0;
              done <= 1'b1;
            end else begin
              bidx <= bidx + 1'b1;
              cur  <= cur + 1'b1;
              ph   <= ADJ;
              cnt  <= adj_l;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BASE) begin
      bus_rdata[0]              = en;
      bus_rdata[LEN_LSB +: LW]  = len;
      bus_rdata[SA_LSB +: AW]   = sa;
      bus_rdata[HALF_BIT]       = half;
    end else if (bus_addr == OFF_CFG) begin
      bus_rdata[STB_LSB +: CW] = cfg_stb;
      bus_rdata[ADJ_LSB +: CW] = cfg_adj;
    end else if (bus_addr == OFF_STAT) begin
      bus_rdata[0] = done;
    end else begin
      for (int w = 0; w < NW; w++)
        if (bus_addr == OFF_DATA + 8'(4 * w))
          bus_rdata = {dbuf[4*w+3], dbuf[4*w+2], dbuf[4*w+1], dbuf[4*w]};
    end
  end
endmodule

// File: rtl/efuse_rd_ctrl_chk.sv
module efuse_rd_ctrl_chk #(
  parameter int AW = 9,
  parameter int LW = 5,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fuse_strobe,
  input logic [AW:0]   fuse_addr,
  input logic          done,
  input logic          busy,
  input logic          wr_ctrl,
  input logic [CW-1:0] stb_l,
  input logic [AW-1:0] sa,
  input logic [LW-1:0] len
);
  logic [CW:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= fuse_strobe ? run + 1'b1 : '0;

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> run <= {1'b0, stb_l});
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));
  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fuse_strobe));
  assert_no_strobe_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> !done);
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> ($stable(sa) && $stable(len)));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind efuse_rd_ctrl efuse_rd_ctrl_chk #(.AW(AW), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr),
  .done(done), .busy(busy), .wr_ctrl(wr_ctrl), .stb_l(stb_l), .sa(sa), .len(len)
);

// File: tb/tb_efuse_rd_ctrl.sv
module tb_efuse_rd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [9:0] fuse_addr;
  logic fuse_strobe;
  logic [7:0] fuse_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fmodel(logic [9:0] a);
    return (a[7:0] * 8'd13) ^ {a[9:8], 6'h15};
  endfunction
  assign fuse_rdata = fmodel(fuse_addr);

  efuse_rd_ctrl dut (.*);

  function automatic logic [31:0] exp_word(int sa, int n, bit h, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      int i = w * 4 + b;
      logic [8:0] o = 9'(sa + i);
      if (i < n) r[8*b +: 8] = fmodel({h, o});
    end
    return r;
  endfunction

  function automatic logic [31:0] ctrl_word(int sa, int n, bit h, bit go);
    return {1'b0, h, 9'(sa), 5'(n - 1), 15'b0, go};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_data(int sa, int n, bit h, string note);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      br(8'hdc + 8'(4 * w), v);
      chk((w * 4 < n) ? {"R6 ", note} : {"R7 ", note}, v, exp_word(sa, n, h, w));
    end
  endtask

  task automatic do_read(int sa, int n, bit h, int adj, int stb, bit inject);
    logic [31:0] v;
    int k = 0, sc = 0;
    bit seen_busy = 1'b0;
    bw(8'hd4, {8'h0, 4'(adj), 4'(stb), 16'h0});
    bw(8'hd0, ctrl_word(sa, n, h, 1'b1));
    forever begin
      br(8'hd8, v);
      if (v[0]) break;
      if (k == 1) begin
        br(8'hd0, v);
        chk("R10 busy readback", v, ctrl_word(sa, n, h, 1'b1));
        seen_busy = 1'b1;
      end
      if (inject && k == 1) begin
        bw(8'hd0, ctrl_word(sa + 77, 32, !h, 1'b1));
        k++;
      end else begin
        if (fuse_strobe) sc++;
        @(negedge clk);
        k++;
      end
      if (k > 3000) break;
    end
    if (!inject) begin
      chk("R5 done latency", 32'(k), 32'(n * (adj + stb + 2)));
      chk("R5 strobe cycles", 32'(sc), 32'(n * (stb + 1)));
    end
    chk("R8 done set", {31'b0, v[0]}, 32'd1);
    br(8'hd0, v);
    chk(inject ? "R9 ctrl unchanged" : "R10 self clear", v, ctrl_word(sa, n, h, 1'b0));
    check_data(sa, n, h, inject ? "R9 data" : "data");
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe", {31'b0, fuse_strobe}, 32'd0);
    for (int a = 8'hd0; a <= 8'hfc; a += 4) begin
      br(8'(a), v);
      chk("R1 reset regs", v, 32'd0);
    end
    bw(8'hd4, 32'hffff_ffff);
    br(8'hd4, v); chk("R4 cfg fields", v, 32'h00ff_0000);
    bw(8'hfc, 32'hdead_beef);
    br(8'hfc, v); chk("R2 unmapped fc", v, 32'd0);
    br(8'h00, v); chk("R2 unmapped 00", v, 32'd0);

    do_read(5, 1, 1'b0, 0, 0, 1'b0);
    do_read(40, 3, 1'b0, 2, 1, 1'b0);
    do_read(100, 32, 1'b0, 1, 3, 1'b0);
    do_read(8'h10, 9, 1'b1, 0, 2, 1'b0);     // R12 half set with low offset
    do_read(9'h1f8, 16, 1'b0, 3, 0, 1'b0);   // R3 offset wraps at 512
    do_read(0, 4, 1'b0, 15, 15, 1'b0);

    bw(8'hd4, 32'h0055_0000);
    bw(8'hd0, ctrl_word(200, 7, 1'b1, 1'b0));
    br(8'hd8, v); chk("R11 done kept", v, 32'd1);
    check_data(0, 4, 1'b0, "R11 hold");

    do_read(30, 6, 1'b0, 4, 2, 1'b1);        // R9 mid-read control write

    for (int t = 0; t < 20; t++)
      do_read(int'($urandom_range(511)), int'($urandom_range(32, 1)),
              1'($urandom_range(1)), int'($urandom_range(15)),
              int'($urandom_range(15)), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule